// File: doc/BRIEF.md
# USB Host Control Transfer Sequencer

This block runs the host side of one USB control transfer. Software fills four 16-bit request words with the request type and request code, the value, the index and the length. It then pulses `start`. The sequencer issues a SETUP transaction that carries those eight bytes, an optional data stage made of IN or OUT transactions, and a status stage that runs the opposite way. Each transaction goes to a packet engine through a small request/response interface. The sequencer raises `pe_req` for one cycle with a token code, a data PID and a byte count. The engine later answers with a one-cycle `pe_done`, a response code and, for IN tokens, a received byte count. Line signalling, CRC and buffer memory belong to the engine and are not part of this block.

The sequencer keeps the data toggle. It forces DATA0 on the setup packet and DATA1 on the first data packet and on the status packet. On a write whose length is an exact multiple of the maximum packet size, it adds a zero-length OUT packet. `sureq` is high from `start` until the setup transaction gets its answer. While `sureq` is high, writes to the request words are dropped. The result of the setup stage is shown as either `setup_ack` or `setup_err`. A STALL at any stage ends the transfer and sets the sticky flag `stall`.

The states are S_IDLE, S_SETUP_TX, S_SETUP_WT, S_DATA_TX, S_DATA_WT, S_STAT_TX, S_STAT_WT and S_END. The transitions are:
- S_IDLE goes to S_SETUP_TX on `start`.
- Each *_TX state goes to its *_WT state after one cycle.
- S_SETUP_WT goes to S_DATA_TX or S_STAT_TX on ACK, and to S_END otherwise.
- S_DATA_WT goes back to S_DATA_TX on NAK, on no answer, or when more data is due. It goes to S_STAT_TX when the data stage is complete, and to S_END on STALL.
- S_STAT_WT goes back to S_STAT_TX on NAK or no answer, and to S_END on ACK or STALL.
- S_END goes to S_IDLE.

Top module: `usb_ctl_seq`

## Requirements
- R1: `setup_pkt` shows the request words in little-endian byte order: word 0 (selected by `reg_sel`=0, bit 7 = direction, 1 means IN) in bits 15:0, then value (sel 1), index (sel 2) and length (sel 3) in bits 63:48. The setup transaction uses token code 2 (SETUP), `pe_len`=8 and `pe_addr`=`pipe_dev`.
- R2: After reset, `sureq`, `busy`, `pe_req` and all flags are 0. `start` in S_IDLE sets `sureq` at the next edge. `sureq` clears one cycle after the setup response arrives. `start` has no effect while `busy` is high.
- R3: A register write while `sureq`=1 is ignored. The same write is accepted once `sureq` is 0.
- R4: Response codes are ACK=0, NAK=1, STALL=2 and no answer=3. An ACK to SETUP sets `setup_ack`. Any other answer sets `setup_err` and ends the transfer. At most one of the two flags is set, and the flag holds until the next `start`.
- R5: The setup transaction always carries PID DATA0 (`pe_pid`=0).
- R6: The first data-stage packet carries DATA1 (`pe_pid`=1). Its token is IN (code 1) when bit 7 of word 0 is set, and OUT (code 0) otherwise.
- R7: Each ACKed data packet flips the toggle. A NAK or no answer repeats the same packet with the same PID and length.
- R8: The status stage carries DATA1 and zero length. Its token is OUT after an IN data stage, and IN after an OUT data stage or when there is no data stage (length 0). NAK or no answer retries it.
- R9: OUT data packets carry min(remaining, `pipe_mps`) bytes. When the length is a nonzero multiple of `pipe_mps`, a zero-length OUT follows the last full packet.
- R10: An IN data stage ends after an ACKed packet that is shorter than `pipe_mps` or that reaches the requested length.
- R11: A STALL in any stage ends the transfer and sets `stall`. `stall` stays set until the next `start`.
- R12: `xfer_done` pulses for one cycle at the end of every transfer, and `busy` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Request word write strobe |
| reg_sel | input | 2 | Request word select (0 type/request, 1 value, 2 index, 3 length) |
| reg_wdata | input | 16 | Request word write data |
| pipe_dev | input | ADDR_W | Target device address |
| pipe_mps | input | MPS_W | Maximum packet size in bytes (nonzero) |
| start | input | 1 | Setup request pulse |
| sureq | output | 1 | Setup request pending |
| busy | output | 1 | Transfer in progress |
| setup_pkt | output | 64 | Eight setup bytes, byte 0 in bits 7:0 |
| pe_req | output | 1 | Transaction request strobe |
| pe_tok | output | 2 | Token: 0 OUT, 1 IN, 2 SETUP |
| pe_pid | output | 1 | Data PID: 0 DATA0, 1 DATA1 |
| pe_len | output | MPS_W | Bytes to send (0 for IN tokens) |
| pe_addr | output | ADDR_W | Device address for the transaction |
| pe_done | input | 1 | Transaction finished strobe |
| pe_resp | input | 2 | Response code |
| pe_rx_len | input | MPS_W | Bytes received on an IN token |
| setup_ack | output | 1 | Setup stage acknowledged |
| setup_err | output | 1 | Setup stage not acknowledged |
| stall | output | 1 | Sticky STALL seen |
| xfer_done | output | 1 | Transfer end pulse |

## Verification
The bench builds the block with its default widths: MPS_W=7, ADDR_W=7 and a 16-bit length. The maximum packet size is an input, so the bench drives it to 8 at run time. With that setting, a transfer of a few tens of bytes already covers several packets. It also reaches the exact-multiple zero-length case, short IN packets, and an IN stage that stops at the requested length, all within a short run. A behavioural model uses the planned response script to predict the token, PID and length of every transaction. That prediction is compared with each request as it appears.

// File: rtl/usb_ctl_pkg.sv
package usb_ctl_pkg;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2
    } tok_e;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_NONE  = 2'd3
    } rsp_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP_TX,
        S_SETUP_WT,
        S_DATA_TX,
        S_DATA_WT,
        S_STAT_TX,
        S_STAT_WT,
        S_END
    } st_e;

    localparam int SETUP_BYTES = 8;
    localparam int REQ_WORDS   = 4;
    localparam int WORD_W      = 16;

endpackage

// File: rtl/ctl_req_regs.sv
module ctl_req_regs
    import usb_ctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [1:0]                sel,
    input  logic [WORD_W-1:0]         wdata,
    input  logic                      lock,
    output logic [REQ_WORDS*WORD_W-1:0] pkt,
    output logic                      dir_in,
    output logic [WORD_W-1:0]         len
);

    logic [WORD_W-1:0] words [REQ_WORDS];

    for (genvar g = 0; g < REQ_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr && !lock && (sel == 2'(g)))
                words[g] <= wdata;
        end
        assign pkt[g*WORD_W +: WORD_W] = words[g];
    end

    assign dir_in = words[0][7];
    assign len    = words[REQ_WORDS-1];

    // R3: request words frozen while setup request pending
    p_reg_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(pkt));

endmodule

// File: rtl/ctl_byte_cnt.sv
module ctl_byte_cnt #(
    parameter int LEN_W = 16,
    parameter int MPS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             consume,
    input  logic [MPS_W-1:0] amount,
    input  logic [MPS_W-1:0] mps,
    output logic [LEN_W-1:0] rem,
    output logic [MPS_W-1:0] chunk
);

    logic [LEN_W-1:0] amt_ext, mps_ext;

    assign amt_ext = LEN_W'(amount);
    assign mps_ext = LEN_W'(mps);

    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= load_len;
        else if (consume)
            rem <= (amt_ext >= rem) ? '0 : rem - amt_ext;
    end

    assign chunk = (rem < mps_ext) ? rem[MPS_W-1:0] : mps;

    // R9: the remaining count only shrinks between loads
    p_rem_never_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> rem <= $past(rem));

endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
    import usb_ctl_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int MPS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             req_dir_in,
    input  logic             req_len_nz,
    input  logic [MPS_W-1:0] mps,
    input  logic [LEN_W-1:0] cnt_rem,
    input  logic [MPS_W-1:0] cnt_chunk,
    input  logic             pe_done,
    input  logic [1:0]       pe_resp,
    input  logic [MPS_W-1:0] pe_rx_len,
    output logic             sureq,
    output logic             busy,
    output logic             pe_req,
    output logic [1:0]       pe_tok,
    output logic             pe_pid,
    output logic [MPS_W-1:0] pe_len,
    output logic             cnt_load,
    output logic             cnt_consume,
    output logic [MPS_W-1:0] cnt_amount,
    output logic             setup_ack,
    output logic             setup_err,
    output logic             stall,
    output logic             xfer_done
);

    st_e  state, nxt;
    rsp_e resp;
    logic tog, zlp, dir_in, has_data;
    logic in_end, out_last, out_full, out_end, go;

    assign resp     = rsp_e'(pe_resp);
    assign go       = (state == S_IDLE) && start;
    assign in_end   = (pe_rx_len < mps) || (LEN_W'(pe_rx_len) >= cnt_rem);
    assign out_last = (cnt_rem == LEN_W'(cnt_chunk));
    assign out_full = (cnt_chunk == mps);
    assign out_end  = zlp || (out_last && !out_full);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = S_SETUP_TX;
            S_SETUP_TX: nxt = S_SETUP_WT;
            S_SETUP_WT: if (pe_done)
                            nxt = (resp != RSP_ACK) ? S_END :
                                  (has_data ? S_DATA_TX : S_STAT_TX);
            S_DATA_TX:  nxt = S_DATA_WT;
            S_DATA_WT:  if (pe_done) begin
                            unique case (resp)
                                RSP_ACK:   nxt = (dir_in ? in_end : out_end) ? S_STAT_TX : S_DATA_TX;
                                RSP_STALL: nxt = S_END;
                                RSP_NAK,
                                RSP_NONE:  nxt = S_DATA_TX;
                            endcase
                        end
            S_STAT_TX:  nxt = S_STAT_WT;
            S_STAT_WT:  if (pe_done)
                            nxt = (resp == RSP_ACK || resp == RSP_STALL) ? S_END : S_STAT_TX;
            S_END:      nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register and tracked transfer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            sureq     <= 1'b0;
            tog       <= 1'b0;
            zlp       <= 1'b0;
            dir_in    <= 1'b0;
            has_data  <= 1'b0;
            setup_ack <= 1'b0;
            setup_err <= 1'b0;
            stall     <= 1'b0;
        end else begin
            state <= nxt;
            if (go) begin
                sureq     <= 1'b1;
                dir_in    <= req_dir_in;
                has_data  <= req_len_nz;
                tog       <= 1'b0;
                zlp       <= 1'b0;
                setup_ack <= 1'b0;
                setup_err <= 1'b0;
                stall     <= 1'b0;
            end
            if (state == S_SETUP_WT && pe_done) begin
                sureq     <= 1'b0;
                tog       <= 1'b1;
                setup_ack <= (resp == RSP_ACK);
                setup_err <= (resp != RSP_ACK);
                stall     <= (resp == RSP_STALL);
            end
            if (state == S_DATA_WT && pe_done) begin
                if (resp == RSP_ACK) begin
                    tog <= ~tog;
                    if (!dir_in) begin
                        if (zlp)
                            zlp <= 1'b0;
                        else if (out_last && out_full)
                            zlp <= 1'b1;
                    end
                end else if (resp == RSP_STALL) begin
                    stall <= 1'b1;
                end
            end
            if (state == S_STAT_WT && pe_done && resp == RSP_STALL)
                stall <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        pe_req      = 1'b0;
        pe_tok      = TOK_OUT;
        pe_pid      = 1'b0;
        pe_len      = '0;
        busy        = (state != S_IDLE);
        xfer_done   = (state == S_END);
        cnt_load    = go;
        cnt_consume = (state == S_DATA_WT) && pe_done && (resp == RSP_ACK) && !zlp;
        cnt_amount  = dir_in ? pe_rx_len : cnt_chunk;
        unique case (state)
            S_SETUP_TX, S_SETUP_WT: begin
                pe_req = (state == S_SETUP_TX);
                pe_tok = TOK_SETUP;
                pe_pid = 1'b0;
                pe_len = MPS_W'(SETUP_BYTES);
            end
            S_DATA_TX, S_DATA_WT: begin
                pe_req = (state == S_DATA_TX);
                pe_tok = dir_in ? TOK_IN : TOK_OUT;
                pe_pid = tog;
                pe_len = (dir_in || zlp) ? '0 : cnt_chunk;
            end
            S_STAT_TX, S_STAT_WT: begin
                pe_req = (state == S_STAT_TX);
                pe_tok = (dir_in && has_data) ? TOK_OUT : TOK_IN;
                pe_pid = 1'b1;
            end
            default: ;
        endcase
    end

    p_sureq_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SETUP_WT && pe_done) |=> !sureq);

    p_setup_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({setup_ack, setup_err}));

    p_setup_data0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req && pe_tok == TOK_SETUP) |-> !pe_pid);

    p_first_data1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA_TX && $past(state) == S_SETUP_WT) |-> pe_pid);

    p_nak_keeps_tog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA_WT && pe_done && resp != RSP_ACK) |=> tog == $past(tog));

    p_status_data1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req && state == S_STAT_TX) |-> (pe_pid && pe_len == '0));

    p_stall_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !go) |=> stall);

    p_done_then_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !busy);

endmodule

// File: rtl/usb_ctl_seq.sv
module usb_ctl_seq
    import usb_ctl_pkg::*;
#(
    parameter int MPS_W  = 7,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [15:0]       reg_wdata,
    input  logic [ADDR_W-1:0] pipe_dev,
    input  logic [MPS_W-1:0]  pipe_mps,
    input  logic              start,
    output logic              sureq,
    output logic              busy,
    output logic [63:0]       setup_pkt,
    output logic              pe_req,
    output logic [1:0]        pe_tok,
    output logic              pe_pid,
    output logic [MPS_W-1:0]  pe_len,
    output logic [ADDR_W-1:0] pe_addr,
    input  logic              pe_done,
    input  logic [1:0]        pe_resp,
    input  logic [MPS_W-1:0]  pe_rx_len,
    output logic              setup_ack,
    output logic              setup_err,
    output logic              stall,
    output logic              xfer_done
);

    localparam int LEN_W = WORD_W;

    logic             req_dir_in;
    logic [LEN_W-1:0] req_len;
    logic             cnt_load, cnt_consume;
    logic [MPS_W-1:0] cnt_amount, cnt_chunk;
    logic [LEN_W-1:0] cnt_rem;

    ctl_req_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .lock   (sureq),
        .pkt    (setup_pkt),
        .dir_in (req_dir_in),
        .len    (req_len)
    );

    ctl_byte_cnt #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_len (req_len),
        .consume  (cnt_consume),
        .amount   (cnt_amount),
        .mps      (pipe_mps),
        .rem      (cnt_rem),
        .chunk    (cnt_chunk)
    );

    ctl_seq_fsm #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_dir_in  (req_dir_in),
        .req_len_nz  (req_len != '0),
        .mps         (pipe_mps),
        .cnt_rem     (cnt_rem),
        .cnt_chunk   (cnt_chunk),
        .pe_done     (pe_done),
        .pe_resp     (pe_resp),
        .pe_rx_len   (pe_rx_len),
        .sureq       (sureq),
        .busy        (busy),
        .pe_req      (pe_req),
        .pe_tok      (pe_tok),
        .pe_pid      (pe_pid),
        .pe_len      (pe_len),
        .cnt_load    (cnt_load),
        .cnt_consume (cnt_consume),
        .cnt_amount  (cnt_amount),
        .setup_ack   (setup_ack),
        .setup_err   (setup_err),
        .stall       (stall),
        .xfer_done   (xfer_done)
    );

    assign pe_addr = pipe_dev;

endmodule

// File: tb/sim_usb_ctl_seq.sv
module sim_usb_ctl_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [6:0]  pipe_dev = 7'h2A;
    logic [6:0]  pipe_mps = 7'd8;
    logic        start = 1'b0;
    logic        sureq, busy, pe_req, pe_pid, setup_ack, setup_err, stall, xfer_done;
    logic [63:0] setup_pkt;
    logic [1:0]  pe_tok;
    logic [6:0]  pe_len, pe_addr;
    logic        pe_done = 1'b0;
    logic [1:0]  pe_resp = '0;
    logic [6:0]  pe_rx_len = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int rs_resp[$];
    int rs_rx[$];
    int ex_tok[$];
    int ex_pid[$];
    int ex_len[$];
    bit ex_ack, ex_err, ex_stall;
    logic [63:0] exp_pkt;

    always #4 clk = ~clk;

    usb_ctl_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .pipe_dev(pipe_dev), .pipe_mps(pipe_mps),
        .start(start), .sureq(sureq), .busy(busy), .setup_pkt(setup_pkt),
        .pe_req(pe_req), .pe_tok(pe_tok), .pe_pid(pe_pid), .pe_len(pe_len),
        .pe_addr(pe_addr), .pe_done(pe_done), .pe_resp(pe_resp),
        .pe_rx_len(pe_rx_len), .setup_ack(setup_ack), .setup_err(setup_err),
        .stall(stall), .xfer_done(xfer_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input int t, input int p, input int l);
        ex_tok.push_back(t); ex_pid.push_back(p); ex_len.push_back(l);
    endtask

    task automatic pr(input int r, input int rx);
        rs_resp.push_back(r); rs_rx.push_back(rx);
    endtask

    // behavioural model: walk the response script and list the expected transactions
    task automatic predict(input bit din, input int len, input int mps);
        int i, tog, rem, r, rx, n, stok;
        bit zlp;
        zlp = 0;
        ex_ack = 0; ex_err = 0; ex_stall = 0;
        push_exp(2, 0, 8);
        r = rs_resp[0]; i = 1;
        if (r != 0) begin ex_err = 1; ex_stall = (r == 2); return; end
        ex_ack = 1; tog = 1; rem = len;
        if (len > 0) begin
            while (i < rs_resp.size()) begin
                if (din) begin
                    push_exp(1, tog, 0);
                    r = rs_resp[i]; rx = rs_rx[i]; i++;
                    if (r == 2) begin ex_stall = 1; return; end
                    if (r == 0) begin
                        tog ^= 1;
                        if (rx < mps || rx >= rem) break;
                        rem -= rx;
                    end
                end else begin
                    n = zlp ? 0 : (rem < mps ? rem : mps);
                    push_exp(0, tog, n);
                    r = rs_resp[i]; i++;
                    if (r == 2) begin ex_stall = 1; return; end
                    if (r == 0) begin
                        tog ^= 1;
                        if (zlp) break;
                        rem -= n;
                        if (rem == 0) begin
                            if (n == mps) zlp = 1;
                            else break;
                        end
                    end
                end
            end
        end
        stok = (din && len > 0) ? 0 : 1;
        while (i < rs_resp.size()) begin
            push_exp(stok, 1, 0);
            r = rs_resp[i]; i++;
            if (r == 0) break;
            if (r == 2) begin ex_stall = 1; return; end
        end
    endtask

    // packet engine: checks each request against the model, answers two cycles later
    initial begin
        int cnt, r, rx;
        cnt = 0; r = 0; rx = 0;
        forever begin
            @(negedge clk);
            pe_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    pe_done = 1'b1; pe_resp = 2'(r); pe_rx_len = 7'(rx);
                end
            end
            if (pe_req && rst_n) begin
                if (ex_tok.size() == 0) begin
                    chk(0, "R7 unexpected transaction", pe_tok, 0);
                    r = 0; rx = 0;
                end else begin
                    int t, p, l;
                    t = ex_tok.pop_front(); p = ex_pid.pop_front(); l = ex_len.pop_front();
                    // R5 R6 R7 R8 R9 R10: token, PID and length per transaction
                    chk(pe_tok == 2'(t) && pe_pid == 1'(p) && pe_len == 7'(l),
                        "R5/R6/R7/R8/R9/R10 txn {tok,pid,len}",
                        {pe_tok, 3'b0, pe_pid, 1'b0, pe_len}, {2'(t), 3'b0, 1'(p), 1'b0, 7'(l)});
                    if (t == 2) // R1 setup contents and address
                        chk(setup_pkt == exp_pkt && pe_addr == pipe_dev, "R1 setup bytes/addr",
                            setup_pkt, exp_pkt);
                    r  = (rs_resp.size() > 0) ? rs_resp.pop_front() : 0;
                    rx = (rs_rx.size() > 0) ? rs_rx.pop_front() : 0;
                end
                cnt = 2;
            end
        end
    end

    task automatic wr(input int sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input bit din, input int len, input int mps, input bit lock_test);
        logic [15:0] w0, wv;
        bit seen;
        w0 = {8'h06, din ? 8'h80 : 8'h00};
        wv = 16'h0100 + 16'(len);
        @(negedge clk);
        wr(0, w0); wr(1, wv); wr(2, 16'h0003); wr(3, 16'(len));
        exp_pkt = {16'(len), 16'h0003, wv, w0};
        pipe_mps = 7'(mps);
        predict(din, len, mps);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sureq == 1'b1, "R2 sureq set after start", sureq, 1);
        if (lock_test) begin
            // R3 write while sureq is high; R2 start again while busy
            reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'hBEEF; start = 1'b1;
            @(negedge clk);
            reg_wr = 1'b0; start = 1'b0;
            chk(setup_pkt == exp_pkt, "R3 write ignored while sureq", setup_pkt, exp_pkt);
        end
        seen = 0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            if (xfer_done) seen = 1;
        end
        chk(seen, "R12 xfer_done pulse", seen, 1);
        chk({setup_ack, setup_err, stall} == {ex_ack, ex_err, ex_stall},
            "R4/R11 flags {ack,err,stall}", {setup_ack, setup_err, stall}, {ex_ack, ex_err, ex_stall});
        chk(sureq == 1'b0, "R2 sureq cleared", sureq, 0);
        @(negedge clk);
        chk(busy == 1'b0 && xfer_done == 1'b0, "R12 idle after done", {busy, xfer_done}, 0);
        chk(ex_tok.size() == 0, "R8 missing transactions", ex_tok.size(), 0);
        ex_tok.delete(); ex_pid.delete(); ex_len.delete(); rs_resp.delete(); rs_rx.delete();
        if (lock_test) begin
            wr(1, 16'hBEEF);
            chk(setup_pkt[31:16] == 16'hBEEF, "R3 write accepted when idle", setup_pkt[31:16], 16'hBEEF);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({sureq, busy, pe_req, setup_ack, setup_err, stall, xfer_done} == 7'b0,
            "R2 reset state", {sureq, busy, pe_req, setup_ack, setup_err, stall, xfer_done}, 0);
        chk(setup_pkt == 64'd0, "R1 reset words", setup_pkt, 0);
        rst_n = 1'b1;

        // R9 exact multiple write with NAK retry (R7) and ZLP
        pr(0,0); pr(1,0); pr(0,0); pr(0,0); pr(0,0); pr(0,0);
        run(0, 16, 8, 1);
        // R9 partial last packet, R8 status NAK retry
        pr(0,0); pr(0,0); pr(0,0); pr(1,0); pr(0,0);
        run(0, 10, 8, 0);
        // R10 IN over three packets with a no-answer retry
        pr(0,0); pr(0,8); pr(3,0); pr(0,8); pr(0,4); pr(0,0);
        run(1, 20, 8, 0);
        // R10 short IN packet ends stage early
        pr(0,0); pr(0,8); pr(0,3); pr(0,0);
        run(1, 64, 8, 0);
        // R8 no data stage
        pr(0,0); pr(0,0);
        run(0, 0, 8, 0);
        // R4 setup unanswered
        pr(3,0);
        run(0, 8, 8, 0);
        // R11 stall in data stage
        pr(0,0); pr(0,0); pr(2,0);
        run(0, 24, 8, 0);
        // R10 IN reaching length exactly, R11 stall cleared by start
        pr(0,0); pr(0,8); pr(0,0);
        run(1, 8, 8, 0);
        // R4 R11 setup stalled
        pr(2,0);
        run(1, 8, 8, 0);
        // R9 larger packet size, status stall R11
        pipe_dev = 7'h05;
        pr(0,0); pr(0,0); pr(0,0); pr(2,0);
        run(0, 100, 64, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule